// File: doc/BRIEF.md
# Cascaded DMA Request Mask Unit

This block keeps the request-mask state for an eight-channel DMA subsystem. The channels form two groups of four. The lower group (channels 0-3) feeds into channel 4 of the upper group (channels 4-7). Each channel has one mask bit. A set bit blocks that channel's incoming request and a cleared bit lets it through.

Software changes the masks over a small register bus with address, write data, write strobe and read strobe. Each group has two write commands. One changes the mask of a single selected channel. The other loads all four masks of the group at once, and reading its address returns the group's mask status. Hardware can also set mask bits: at terminal count on a channel that does not autoinitialize, and through a per-group master clear. Because of the cascade, masking channel 4 also silences every lower-group request at the outputs. The lower group's stored mask bits are not changed by this.

Top module: `dmsk_unit`

## Requirements
- R1: After reset all eight mask bits are set. Every `dreq_out` bit is 0, and reads of 0x0F and 0xDE both return 0x0F.
- R2: A write to 0x0A (lower group) or 0xD4 (upper group) selects the channel within the group with data bits 1:0. It sets that channel's mask when data bit 2 is 1 and clears it when bit 2 is 0. All other mask bits are left unchanged.
- R3: A write to 0x0F (lower group) or 0xDE (upper group) loads data bits 3:0 into the group's masks, with bit n going to local channel n. Data bits 7:4 are ignored.
- R4: While `bus_rd` is high, `bus_rdata` shows the group's masks on bits 3:0 for address 0x0F or 0xDE, with bits 7:4 at 0. Any other address, or `bus_rd` low, gives 0.
- R5: For channels 4-7, `dreq_out[n]` equals `dreq_in[n]` AND NOT mask[n]. This follows the mask state from the clock edge after the write.
- R6: For channels 0-3, `dreq_out[n]` equals `dreq_in[n]` AND NOT mask[n] AND NOT mask[4]. Setting channel 4's mask leaves the stored lower masks, as read at 0x0F, unchanged.
- R7: A `tc_pulse[n]` while `auto_init[n]` is 0 sets mask[n] at the next clock edge.
- R8: A `tc_pulse[n]` while `auto_init[n]` is 1 leaves mask[n] unchanged.
- R9: When a terminal-count set and a software write hit the same channel in the same cycle, the mask ends up set.
- R10: `mclr_lo` sets masks 0-3 and `mclr_hi` sets masks 4-7. Each leaves the other group's masks unchanged.
- R11: A write to any address other than the four command addresses changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| dreq_in | input | 8 | Raw channel requests |
| tc_pulse | input | 8 | Terminal-count pulse per channel |
| auto_init | input | 8 | Autoinitialize flag per channel |
| mclr_lo | input | 1 | Master clear, channels 0-3 |
| mclr_hi | input | 1 | Master clear, channels 4-7 |
| dreq_out | output | 8 | Requests after masking and cascade gating |

## Verification
The gating is tried with two request patterns: all-ones, and an alternating 0x5A. These show whether one channel's mask leaks into another channel's output. Masking channel 4 is done both by a single-channel write and by a whole-group write. In each case a read of the lower group confirms that only the outputs were gated and that the stored lower bits were not touched. Terminal count is applied with and without autoinitialize, and together with a conflicting clear in the same cycle. Master clear is applied to each group, and writes are made to an unused address. Together these tell apart the correct priority order and group isolation from a design that blends its write paths together.

// File: rtl/dmsk_pkg.sv
package dmsk_pkg;
   localparam int GRP_LO = 0;
   localparam int GRP_HI = 1;
   localparam int NUM_GRP = 2;

   typedef struct packed {
      logic single_we;
      logic all_we;
      logic rd_hit;
   } grp_sel_t;
endpackage

// File: rtl/dmsk_decode.sv
module dmsk_decode
   import dmsk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] LO_SINGLE_ADDR = 'h0A,
   parameter logic [ADDR_W-1:0] LO_ALL_ADDR    = 'h0F,
   parameter logic [ADDR_W-1:0] HI_SINGLE_ADDR = 'hD4,
   parameter logic [ADDR_W-1:0] HI_ALL_ADDR    = 'hDE
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   wr,
   output grp_sel_t [NUM_GRP-1:0] sel
);
   localparam logic [NUM_GRP-1:0][ADDR_W-1:0] SINGLE_TBL = {HI_SINGLE_ADDR, LO_SINGLE_ADDR};
   localparam logic [NUM_GRP-1:0][ADDR_W-1:0] ALL_TBL    = {HI_ALL_ADDR, LO_ALL_ADDR};

   if (LO_SINGLE_ADDR == LO_ALL_ADDR || HI_SINGLE_ADDR == HI_ALL_ADDR ||
       LO_ALL_ADDR == HI_ALL_ADDR || LO_SINGLE_ADDR == HI_SINGLE_ADDR) begin : g_addr_clash
      initial $error("dmsk_decode: command addresses must be distinct");
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      always_comb begin
         sel[g].single_we = wr && (addr == SINGLE_TBL[g]);
         sel[g].all_we    = wr && (addr == ALL_TBL[g]);
         sel[g].rd_hit    = (addr == ALL_TBL[g]);
      end
   end
endmodule

// File: rtl/dmsk_group.sv
module dmsk_group #(
   parameter int GROUP_CH = 4,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mclr,
   input  logic                single_we,
   input  logic                all_we,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [GROUP_CH-1:0] tc,
   input  logic [GROUP_CH-1:0] autoinit,
   output logic [GROUP_CH-1:0] mask
);
   localparam int SEL_W   = (GROUP_CH > 1) ? $clog2(GROUP_CH) : 1;
   localparam int VAL_BIT = SEL_W;

   if (GROUP_CH < 2 || GROUP_CH > DATA_W || VAL_BIT >= DATA_W) begin : g_bad_cfg
      initial $error("dmsk_group: GROUP_CH must be 2..DATA_W with room for the value bit");
   end

   logic [SEL_W-1:0] sel_ch;
   logic             sel_val;
   assign sel_ch  = wdata[SEL_W-1:0];
   assign sel_val = wdata[VAL_BIT];

   for (genvar i = 0; i < GROUP_CH; i++) begin : g_ch
      logic tc_set;
      logic hit;
      assign tc_set = tc[i] && !autoinit[i];
      assign hit    = single_we && (sel_ch == SEL_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)          mask[i] <= 1'b1;
         else if (mclr)       mask[i] <= 1'b1;
         else if (tc_set)     mask[i] <= 1'b1;
         else if (hit)        mask[i] <= sel_val;
         else if (all_we)     mask[i] <= wdata[i];
      end

      // R7
      tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tc[i] && !autoinit[i]) |=> mask[i]);

      // R8
      tc_autoinit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tc[i] && autoinit[i] && !mclr && !single_we && !all_we) |=> $stable(mask[i]));

      // R2
      single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (single_we && (wdata[SEL_W-1:0] == SEL_W'(i)) && !mclr && !(tc[i] && !autoinit[i]))
         |=> (mask[i] == $past(wdata[VAL_BIT])));
   end

   // R10
   mclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (&mask));
endmodule

// File: rtl/dmsk_gate.sv
module dmsk_gate #(
   parameter int GROUP_CH   = 4,
   parameter bit CASCADE_EN = 1'b1,
   parameter int CASCADE_CH = 0
) (
   input  logic [GROUP_CH-1:0] req_lo,
   input  logic [GROUP_CH-1:0] req_hi,
   input  logic [GROUP_CH-1:0] mask_lo,
   input  logic [GROUP_CH-1:0] mask_hi,
   output logic [GROUP_CH-1:0] out_lo,
   output logic [GROUP_CH-1:0] out_hi
);
   if (CASCADE_CH < 0 || CASCADE_CH >= GROUP_CH) begin : g_bad_casc
      initial $error("dmsk_gate: CASCADE_CH out of range");
   end

   assign out_hi = req_hi & ~mask_hi;

   if (CASCADE_EN) begin : g_cascade
      assign out_lo = req_lo & ~mask_lo & {GROUP_CH{~mask_hi[CASCADE_CH]}};
   end else begin : g_flat
      assign out_lo = req_lo & ~mask_lo;
   end
endmodule

// File: rtl/dmsk_unit.sv
module dmsk_unit
   import dmsk_pkg::*;
#(
   parameter int GROUP_CH   = 4,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int CASCADE_CH = 0,
   parameter logic [ADDR_W-1:0] LO_SINGLE_ADDR = 'h0A,
   parameter logic [ADDR_W-1:0] LO_ALL_ADDR    = 'h0F,
   parameter logic [ADDR_W-1:0] HI_SINGLE_ADDR = 'hD4,
   parameter logic [ADDR_W-1:0] HI_ALL_ADDR    = 'hDE,
   localparam int NUM_CH = NUM_GRP * GROUP_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] dreq_in,
   input  logic [NUM_CH-1:0] tc_pulse,
   input  logic [NUM_CH-1:0] auto_init,
   input  logic              mclr_lo,
   input  logic              mclr_hi,
   output logic [NUM_CH-1:0] dreq_out
);
   grp_sel_t [NUM_GRP-1:0]                sel;
   logic     [NUM_GRP-1:0][GROUP_CH-1:0]  mask;
   logic     [NUM_GRP-1:0]                mclr_v;

   assign mclr_v = {mclr_hi, mclr_lo};

   dmsk_decode #(
      .ADDR_W(ADDR_W),
      .LO_SINGLE_ADDR(LO_SINGLE_ADDR), .LO_ALL_ADDR(LO_ALL_ADDR),
      .HI_SINGLE_ADDR(HI_SINGLE_ADDR), .HI_ALL_ADDR(HI_ALL_ADDR)
   ) u_decode (
      .addr(bus_addr),
      .wr  (bus_wr),
      .sel (sel)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      dmsk_group #(.GROUP_CH(GROUP_CH), .DATA_W(DATA_W)) u_group (
         .clk      (clk),
         .rst_n    (rst_n),
         .mclr     (mclr_v[g]),
         .single_we(sel[g].single_we),
         .all_we   (sel[g].all_we),
         .wdata    (bus_wdata),
         .tc       (tc_pulse[g*GROUP_CH +: GROUP_CH]),
         .autoinit (auto_init[g*GROUP_CH +: GROUP_CH]),
         .mask     (mask[g])
      );
   end

   dmsk_gate #(.GROUP_CH(GROUP_CH), .CASCADE_EN(1'b1), .CASCADE_CH(CASCADE_CH)) u_gate (
      .req_lo (dreq_in[GRP_LO*GROUP_CH +: GROUP_CH]),
      .req_hi (dreq_in[GRP_HI*GROUP_CH +: GROUP_CH]),
      .mask_lo(mask[GRP_LO]),
      .mask_hi(mask[GRP_HI]),
      .out_lo (dreq_out[GRP_LO*GROUP_CH +: GROUP_CH]),
      .out_hi (dreq_out[GRP_HI*GROUP_CH +: GROUP_CH])
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         for (int g = 0; g < NUM_GRP; g++) begin
            if (sel[g].rd_hit) bus_rdata[GROUP_CH-1:0] = mask[g];
         end
      end
   end

   // R6
   cascade_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask[GRP_HI][CASCADE_CH] |-> (dreq_out[GRP_LO*GROUP_CH +: GROUP_CH] == '0));

   // R4
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/dmsk_unit_bench.sv
`timescale 1ns/1ps
module dmsk_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic [7:0] dreq_in = '0, tc_pulse = '0, auto_init = '0;
   logic       mclr_lo = 1'b0, mclr_hi = 1'b0;
   logic [7:0] dreq_out;

   always #10 clk = ~clk;

   dmsk_unit u_dmsk_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .dreq_in(dreq_in), .tc_pulse(tc_pulse), .auto_init(auto_init),
      .mclr_lo(mclr_lo), .mclr_hi(mclr_hi), .dreq_out(dreq_out)
   );

   typedef struct {
      string      req;
      bit         is_read;
      logic [7:0] exp;
   } item_t;

   item_t      sb_q[$];
   int         n_checks = 0, n_fail = 0;
   bit         done = 1'b0;
   logic [7:0] mdl = 8'hFF;

   function automatic logic [7:0] exp_out();
      logic [7:0] o;
      o = dreq_in & ~mdl;
      if (mdl[4]) o[3:0] = 4'h0;
      return o;
   endfunction

   function automatic void mdl_update(logic [7:0] a, logic [7:0] d, bit wr,
                                      logic [7:0] tc, logic [7:0] ai, bit ml, bit mh);
      logic [7:0] nx;
      nx = mdl;
      for (int ch = 0; ch < 8; ch++) begin
         int g, l;
         g = ch / 4;
         l = ch % 4;
         if ((g == 0 && ml) || (g == 1 && mh))                   nx[ch] = 1'b1;
         else if (tc[ch] && !ai[ch])                              nx[ch] = 1'b1;
         else if (wr && a == (g ? 8'hD4 : 8'h0A) && d[1:0] == l[1:0]) nx[ch] = d[2];
         else if (wr && a == (g ? 8'hDE : 8'h0F))                nx[ch] = d[l];
      end
      mdl = nx;
   endfunction

   // monitor: pops expected items and compares against the live outputs
   initial begin
      forever begin
         item_t it;
         logic [7:0] act;
         wait (sb_q.size() != 0);
         it = sb_q.pop_front();
         act = it.is_read ? bus_rdata : dreq_out;
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%02h expected=%02h", it.req,
                     it.is_read ? "rdata" : "dreq_out", act, it.exp);
         end
      end
   end

   task automatic push_out(string req);
      item_t it;
      it.req = req; it.is_read = 1'b0; it.exp = exp_out();
      sb_q.push_back(it);
      #1;
   endtask

   task automatic step(logic [7:0] a, logic [7:0] d, bit wr, logic [7:0] tc,
                       logic [7:0] ai, bit ml, bit mh, string req);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = wr; tc_pulse = tc;
      auto_init = ai; mclr_lo = ml; mclr_hi = mh;
      @(posedge clk);
      mdl_update(a, d, wr, tc, ai, ml, mh);
      @(negedge clk);
      bus_wr = 1'b0; tc_pulse = '0; mclr_lo = 1'b0; mclr_hi = 1'b0;
      push_out(req);
   endtask

   task automatic wr_cmd(logic [7:0] a, logic [7:0] d, string req);
      step(a, d, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, req);
   endtask

   task automatic rd_chk(logic [7:0] a, bit rd, logic [7:0] exp, string req);
      item_t it;
      @(negedge clk);
      bus_addr = a; bus_rd = rd;
      #2;
      it.req = req; it.is_read = 1'b1; it.exp = exp;
      sb_q.push_back(it);
      #1;
      bus_rd = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      dreq_in = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      push_out("R1 reset outputs");
      rd_chk(8'h0F, 1'b1, 8'h0F, "R1 lo reset read");
      rd_chk(8'hDE, 1'b1, 8'h0F, "R1 hi reset read");

      wr_cmd(8'h0F, 8'h00, "R6 lo unmasked but ch4 masked");
      rd_chk(8'h0F, 1'b1, 8'h00, "R3 lo write-all read");
      wr_cmd(8'hDE, 8'hF0, "R3 hi write-all upper bits ignored");
      rd_chk(8'hDE, 1'b1, 8'h00, "R3 hi read");

      wr_cmd(8'hD4, 8'h04, "R6 single set ch4 gates lower");
      rd_chk(8'h0F, 1'b1, 8'h00, "R6 lower stored bits kept");
      wr_cmd(8'hD4, 8'h00, "R2 single clear ch4");
      wr_cmd(8'h0A, 8'h06, "R2 single set ch2");
      rd_chk(8'h0F, 1'b1, 8'h04, "R2 lo read after single");
      wr_cmd(8'hD4, 8'h07, "R5 single set ch7");
      rd_chk(8'hDE, 1'b1, 8'h08, "R5 hi read");

      @(negedge clk); dreq_in = 8'h5A; push_out("R5 pattern 5A");
      wr_cmd(8'hDE, 8'h01, "R6 write-all masks ch4");
      rd_chk(8'h0F, 1'b1, 8'h04, "R6 lower stored after write-all");
      wr_cmd(8'hDE, 8'h00, "R3 hi all clear");

      wr_cmd(8'h0B, 8'hFF, "R11 unused address write");
      rd_chk(8'h0F, 1'b1, 8'h04, "R11 lo unchanged");
      rd_chk(8'h0B, 1'b1, 8'h00, "R4 unused address read");
      rd_chk(8'h0F, 1'b0, 8'h00, "R4 rd low gives zero");

      step(8'h00, 8'h00, 1'b0, 8'h02, 8'h00, 1'b0, 1'b0, "R7 tc sets ch1");
      rd_chk(8'h0F, 1'b1, 8'h06, "R7 lo read");
      step(8'h00, 8'h00, 1'b0, 8'h20, 8'h20, 1'b0, 1'b0, "R8 tc autoinit ch5");
      rd_chk(8'hDE, 1'b1, 8'h00, "R8 hi read");
      step(8'hD4, 8'h02, 1'b1, 8'h40, 8'h00, 1'b0, 1'b0, "R9 tc beats clear ch6");
      rd_chk(8'hDE, 1'b1, 8'h04, "R9 hi read");

      @(negedge clk); dreq_in = 8'hFF; push_out("R5 pattern FF");
      step(8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, "R10 mclr hi");
      rd_chk(8'hDE, 1'b1, 8'h0F, "R10 hi all set");
      rd_chk(8'h0F, 1'b1, 8'h06, "R10 lo untouched");
      wr_cmd(8'hDE, 8'h00, "R3 hi reopen");
      step(8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R10 mclr lo");
      rd_chk(8'h0F, 1'b1, 8'h0F, "R10 lo all set");
      rd_chk(8'hDE, 1'b1, 8'h00, "R10 hi untouched");

      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule